// File: doc/BRIEF.md
# Sleep-State Power Plane Controller

This block holds the system's current power state and turns it into three registered control outputs for external power-plane switches. The states are a working state and five sleep levels of increasing depth. Each state has a fixed output pattern. As the level gets deeper, the first plane switches off first, then the second plane, and finally the active-low hold output releases the main supply.

Software starts a sleep entry by pulsing a request that carries the target level. Only the working state accepts such a request. The block leaves a sleep state by itself when any wake event arrives whose enable bit is set. When it does, it returns to the working state and sets a sticky wake status flag. Software clears the flag by writing 1 to it.

Top module: `pwrplane_ctrl`

## Requirements
- R1: While reset is low, and once it has been released through the internal synchronizer, the block is in the working state. In that state `cur_state` = 0, `plane_a_en` = 1, `plane_b_en` = 1, `rail_hold_n` = 0 and `wake_sts` = 0.
- R2: The state code on `cur_state` equals the level number, with working = 0 and sleep levels 1 to 5. In the working state, a `sleep_req` with `sleep_lvl` between 1 and 5 moves the block to that level on the next clock edge.
- R3: In the working state, a `sleep_req` with `sleep_lvl` equal to 0, 6 or 7 is ignored, and the state stays 0.
- R4: In any sleep level, `sleep_req` is ignored. The state holds until an enabled wake event arrives.
- R5: `plane_a_en` is 1 in states 0 and 1 and is 0 in states 2 to 5.
- R6: `plane_b_en` is 1 in states 0, 1 and 2 and is 0 in states 3 to 5.
- R7: `rail_hold_n` is 0 in states 0 to 3 and is 1 in states 4 and 5.
- R8: The three plane outputs are registered. They take their new values on the same clock edge on which `cur_state` changes.
- R9: In any sleep level, a cycle with any bit set in both `wake_evt` and `wake_en` returns the block to state 0 on the next edge.
- R10: A wake event whose enable bit is clear has no effect. A wake event in the working state changes neither the state nor `wake_sts`.
- R11: A wake-driven return to state 0 sets `wake_sts` to 1 on the same edge.
- R12: A cycle with `sts_wr` = 1 and `sts_wdata` = 1 clears `wake_sts`. A write with `sts_wdata` = 0 leaves it unchanged.
- R13: If a wake-driven set and a clear fall in the same cycle, the set wins and `wake_sts` ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | One-cycle sleep entry request |
| sleep_lvl | input | 3 | Target sleep level for the request |
| wake_evt | input | NUM_WAKE | Wake event sources, one per bit |
| wake_en | input | NUM_WAKE | Per-source wake enables |
| sts_wr | input | 1 | Write strobe for the wake status bit |
| sts_wdata | input | 1 | Written value, where 1 clears the status |
| cur_state | output | 3 | Current state code (0 = working, n = level n) |
| plane_a_en | output | 1 | First plane control, high while that plane is powered |
| plane_b_en | output | 1 | Second plane control, high while that plane is powered |
| rail_hold_n | output | 1 | Active-low main supply hold |
| wake_sts | output | 1 | Sticky wake status |

## Verification
Two functions can act on the status flag in the same cycle. One is the wake-driven set and the other is a software write-1 clear. The bench provokes the collision directly from each sleep level by raising an enabled wake bit in the same cycle as `sts_wr` with `sts_wdata` = 1. It then expects `wake_sts` = 1 and `cur_state` = 0 after that edge, and a clear on the next cycle must then take effect. Random traffic also produces the overlap, and a bench model with set-over-clear priority judges every cycle.

// File: rtl/pwrplane_pkg.sv
package pwrplane_pkg;

  localparam int unsigned STATE_W = 3;
  localparam int unsigned NUM_CTL = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_WORK = 3'd0,
    ST_L1   = 3'd1,
    ST_L2   = 3'd2,
    ST_L3   = 3'd3,
    ST_L4   = 3'd4,
    ST_L5   = 3'd5
  } pstate_e;

  // Control pattern: bit0 plane A enable, bit1 plane B enable, bit2 active-low hold
  function automatic logic [NUM_CTL-1:0] ctl_pattern(input pstate_e s);
    logic [NUM_CTL-1:0] p;
    case (s)
      ST_WORK, ST_L1: p = 3'b011;
      ST_L2:          p = 3'b010;
      ST_L3:          p = 3'b000;
      default:        p = 3'b100;
    endcase
    return p;
  endfunction

  function automatic logic lvl_ok(input logic [STATE_W-1:0] lvl);
    return (lvl >= 3'd1) && (lvl <= 3'd5);
  endfunction

endpackage

// File: rtl/pwrplane_rst_sync.sv
module pwrplane_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwrplane_fsm.sv
module pwrplane_fsm
  import pwrplane_pkg::*;
#(
  parameter int unsigned NUM_WAKE = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic [STATE_W-1:0]  sleep_lvl,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_en,
  output pstate_e             state_q,
  output pstate_e             state_d,
  output logic                state_upd,
  output logic                wake_take
);

  logic wake_hit;

  assign wake_hit = |(wake_evt & wake_en);

  // next-state process
  always_comb begin
    state_d   = state_q;
    wake_take = 1'b0;
    if (state_q == ST_WORK) begin
      if (sleep_req && lvl_ok(sleep_lvl)) begin
        state_d = pstate_e'(sleep_lvl);
      end
    end else if (wake_hit) begin
      state_d   = ST_WORK;
      wake_take = 1'b1;
    end
  end

  assign state_upd = (state_d != state_q);

  // state register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WORK;
    end else if (state_upd) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/pwrplane_outreg.sv
module pwrplane_outreg
  import pwrplane_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  pstate_e            state_d,
  output logic [NUM_CTL-1:0] ctl_q
);

  localparam logic [NUM_CTL-1:0] RST_PAT = ctl_pattern(ST_WORK);

  logic [NUM_CTL-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_pattern(state_d);
  end

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[i] <= RST_PAT[i];
      end else if (upd) begin
        ctl_q[i] <= ctl_d[i];
      end
    end
  end

endmodule

// File: rtl/pwrplane_wake_sts.sv
module pwrplane_wake_sts (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic sts_q
);

  logic clr;
  logic sts_d;
  logic sts_en;

  assign clr = wr_i & wdata_i;

  // set has priority over a write-1 clear
  always_comb begin
    sts_en = set_i | clr;
    sts_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

endmodule

// File: rtl/pwrplane_ctrl.sv
module pwrplane_ctrl
  import pwrplane_pkg::*;
#(
  parameter int unsigned NUM_WAKE = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic [2:0]          sleep_lvl,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                sts_wr,
  input  logic                sts_wdata,
  output logic [2:0]          cur_state,
  output logic                plane_a_en,
  output logic                plane_b_en,
  output logic                rail_hold_n,
  output logic                wake_sts
);

  logic               rst_sync_n;
  pstate_e            state_q;
  pstate_e            state_d;
  logic               state_upd;
  logic               wake_take;
  logic [NUM_CTL-1:0] ctl_q;

  pwrplane_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwrplane_fsm #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sleep_req (sleep_req),
    .sleep_lvl (sleep_lvl),
    .wake_evt  (wake_evt),
    .wake_en   (wake_en),
    .state_q   (state_q),
    .state_d   (state_d),
    .state_upd (state_upd),
    .wake_take (wake_take)
  );

  pwrplane_outreg u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .upd     (state_upd),
    .state_d (state_d),
    .ctl_q   (ctl_q)
  );

  pwrplane_wake_sts u_sts (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (wake_take),
    .wr_i    (sts_wr),
    .wdata_i (sts_wdata),
    .sts_q   (wake_sts)
  );

  assign cur_state   = state_q;
  assign plane_a_en  = ctl_q[0];
  assign plane_b_en  = ctl_q[1];
  assign rail_hold_n = ctl_q[2];

endmodule

// File: rtl/pwrplane_ctrl_chk.sv
module pwrplane_ctrl_chk #(
  parameter int unsigned NUM_WAKE = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_req,
  input logic [2:0]          sleep_lvl,
  input logic [NUM_WAKE-1:0] wake_evt,
  input logic [NUM_WAKE-1:0] wake_en,
  input logic                sts_wr,
  input logic                sts_wdata,
  input logic [2:0]          cur_state,
  input logic                plane_a_en,
  input logic                plane_b_en,
  input logic                rail_hold_n,
  input logic                wake_sts
);

  logic hit;
  logic lvl_good;
  assign hit      = |(wake_evt & wake_en);
  assign lvl_good = (sleep_lvl >= 3'd1) && (sleep_lvl <= 3'd5);

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd0 && sleep_req && lvl_good) |=> (cur_state == $past(sleep_lvl)));

  p_badlvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd0 && sleep_req && !lvl_good) |=> (cur_state == 3'd0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != 3'd0 && !hit) |=> $stable(cur_state));

  p_plane_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    plane_a_en == (cur_state <= 3'd1));

  p_plane_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    plane_b_en == (cur_state <= 3'd2));

  p_hold_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rail_hold_n == (cur_state >= 3'd4));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != 3'd0 && hit) |=> (cur_state == 3'd0));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd0 && !wake_sts) |=> !wake_sts);

  p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != 3'd0 && hit) |=> wake_sts);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_wdata && !(cur_state != 3'd0 && hit)) |=> !wake_sts);

  p_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sts && !(sts_wr && sts_wdata)) |=> wake_sts);

  p_prio_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != 3'd0 && hit && sts_wr && sts_wdata) |=> wake_sts);

endmodule

bind pwrplane_ctrl pwrplane_ctrl_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sleep_req   (sleep_req),
  .sleep_lvl   (sleep_lvl),
  .wake_evt    (wake_evt),
  .wake_en     (wake_en),
  .sts_wr      (sts_wr),
  .sts_wdata   (sts_wdata),
  .cur_state   (cur_state),
  .plane_a_en  (plane_a_en),
  .plane_b_en  (plane_b_en),
  .rail_hold_n (rail_hold_n),
  .wake_sts    (wake_sts)
);

// File: tb/pwrplane_ctrl_bench.sv
`timescale 1ns/1ps
module pwrplane_ctrl_bench;

  localparam int unsigned NW = 12;

  logic          clk;
  logic          rst_n;
  logic          sleep_req;
  logic [2:0]    sleep_lvl;
  logic [NW-1:0] wake_evt;
  logic [NW-1:0] wake_en;
  logic          sts_wr;
  logic          sts_wdata;
  logic [2:0]    cur_state;
  logic          plane_a_en;
  logic          plane_b_en;
  logic          rail_hold_n;
  logic          wake_sts;

  int unsigned n_chk;
  int unsigned n_err;
  bit          done;
  logic [2:0]  m_state;
  logic        m_sts;

  pwrplane_ctrl #(.NUM_WAKE(NW)) u_pwrplane_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_lvl(sleep_lvl),
    .wake_evt(wake_evt), .wake_en(wake_en), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .cur_state(cur_state), .plane_a_en(plane_a_en), .plane_b_en(plane_b_en),
    .rail_hold_n(rail_hold_n), .wake_sts(wake_sts)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2:0] exp_state(logic [2:0] s, logic req, logic [2:0] lvl,
                                           logic hit);
    if (s == 3'd0) return (req && lvl >= 3'd1 && lvl <= 3'd5) ? lvl : 3'd0;
    return hit ? 3'd0 : s;
  endfunction

  function automatic logic exp_sts(logic sts, logic [2:0] s, logic hit, logic we, logic d);
    if (s != 3'd0 && hit) return 1'b1;
    if (we && d) return 1'b0;
    return sts;
  endfunction

  // {plane_a, plane_b, hold_n} per R5, R6, R7
  function automatic logic [2:0] exp_ctl(logic [2:0] s);
    return {s <= 3'd1, s <= 3'd2, s >= 3'd4};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " state R2 R3 R4 R9 R10"}, 32'(cur_state), 32'(m_state));
    chk({tag, " planes R5 R6 R7 R8"}, 32'({plane_a_en, plane_b_en, rail_hold_n}),
        32'(exp_ctl(m_state)));
    chk({tag, " status R11 R12 R13"}, 32'(wake_sts), 32'(m_sts));
  endtask

  // drive at the falling edge, check 1 ns after the rising edge
  task automatic cyc(string tag, logic req, logic [2:0] lvl, logic [NW-1:0] evt,
                     logic [NW-1:0] en, logic we, logic wd);
    logic hit;
    logic [2:0] ns;
    logic nsts;
    sleep_req = req; sleep_lvl = lvl; wake_evt = evt; wake_en = en;
    sts_wr = we; sts_wdata = wd;
    hit  = |(evt & en);
    ns   = exp_state(m_state, req, lvl, hit);
    nsts = exp_sts(m_sts, m_state, hit, we, wd);
    @(posedge clk);
    #1;
    m_state = ns;
    m_sts   = nsts;
    check_all(tag);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 3'd0, '0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    n_chk = 0; n_err = 0; done = 1'b0;
    sleep_req = 0; sleep_lvl = 0; wake_evt = '0; wake_en = '0; sts_wr = 0; sts_wdata = 0;
    m_state = 3'd0; m_sts = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // each level: enter, hold against a request, disabled wake, enabled wake, clear
    for (int l = 1; l <= 5; l++) begin
      cyc("R2 enter", 1'b1, 3'(l), '0, '0, 1'b0, 1'b0);
      cyc("R4 request while asleep", 1'b1, 3'd1, '0, '0, 1'b0, 1'b0);
      cyc("R10 disabled wake", 1'b0, 3'd0, 12'h0F0, 12'h00F, 1'b0, 1'b0);
      cyc("R9 R11 wake", 1'b0, 3'd0, 12'h010, 12'h010, 1'b0, 1'b0);
      cyc("R12 write 0", 1'b0, 3'd0, '0, '0, 1'b1, 1'b0);
      cyc("R12 write 1", 1'b0, 3'd0, '0, '0, 1'b1, 1'b1);
    end

    // invalid levels are ignored
    cyc("R3 level 0", 1'b1, 3'd0, '0, '0, 1'b0, 1'b0);
    cyc("R3 level 6", 1'b1, 3'd6, '0, '0, 1'b0, 1'b0);
    cyc("R3 level 7", 1'b1, 3'd7, '0, '0, 1'b0, 1'b0);
    // wake in working state does nothing
    cyc("R10 wake in S0", 1'b0, 3'd0, '1, '1, 1'b0, 1'b0);

    // set and clear in the same cycle, from every level
    for (int l = 1; l <= 5; l++) begin
      cyc("R13 enter", 1'b1, 3'(l), '0, '0, 1'b0, 1'b0);
      cyc("R13 set beats clear", 1'b0, 3'd0, 12'h800, 12'h800, 1'b1, 1'b1);
      cyc("R12 clear after", 1'b0, 3'd0, '0, '0, 1'b1, 1'b1);
    end

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [NW-1:0] ev;
      ev = (($urandom % 6) == 0) ? NW'($urandom) : '0;
      cyc("random", ($urandom % 3) == 0, 3'($urandom), ev, NW'($urandom & $urandom),
          ($urandom % 5) == 0, 1'($urandom));
    end
    idle("final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule